// File: doc/BRIEF.md
# Overlapped Windowed Single-Bin DFT Demodulator

This block turns a stream of signed ADC samples into complex (in-phase, quadrature) values for one frequency bin. It targets a 1 MHz sample stream and a bin at one fifth of the sample rate (200 kHz). The analysis window is 332 samples long. Two windows run at once, offset by half a window, so a new complex result appears every 166 accepted samples, which is about 6 kHz.

The window weighting is built into the coefficient table, which is computed at elaboration. Each table entry is a Blackman weight multiplied by the cosine or negated sine of the bin phase. The phase is measured from the middle of the window, so a tone that peaks at the window centre yields a purely real result. Each of the two accumulator pairs walks the table with its own counter. When a pair has summed 332 samples, it presents its full-precision totals with a one-cycle strobe and starts a new window. Later stages, such as narrow-band filtering or magnitude and phase conversion, take the I and Q results from the output ports.

Top module: `single_bin_dft`

## Requirements
- R1: `rst_n` low clears both accumulator pairs and both counters and drives `out_valid`, `out_i` and `out_q` to 0. After reset, `out_valid` stays 0 until 332 samples have been accepted.
- R2: The coefficient at window index n (0..331) uses w[n] = 0.42 − 0.5·cos(2πn/331) + 0.08·cos(4πn/331) and θ[n] = 2π·(1/5)·(n − 166). The I coefficient is round(32767·w[n]·cos θ[n]) and the Q coefficient is round(−32767·w[n]·sin θ[n]). Rounding is to the nearest integer, with halves rounded away from zero.
- R3: Each result is I = Σ x[k]·cI[k] and Q = Σ x[k]·cQ[k], taken over the 332 most recently accepted samples in arrival order (k = 0 is the oldest). `in_sample` is 12-bit two's complement. The sums are exact and 37 bits wide, and they do not overflow even when every input is −2048.
- R4: The first result follows the 332nd accepted sample after reset. After that, a result follows every 166 accepted samples, and consecutive windows overlap by 166 samples.
- R5: `out_valid` is high for exactly one clock. It rises on the clock edge that accepts the last sample of a window.
- R6: A cycle with `in_valid` low has no effect on the counters, the sums or the results, whatever value `in_sample` holds.
- R7: Asserting reset in the middle of a stream discards all partial windows. The next result covers only samples accepted after reset.
- R8: `out_i` and `out_q` keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | High when `in_sample` carries a sample this cycle |
| in_sample | input | 12 | Signed ADC sample |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_i | output | 37 | Signed in-phase sum |
| out_q | output | 37 | Signed quadrature sum |

## Verification
The assertions assume that a window always contains more than one accepted sample. Under that assumption two strobes can never fall on adjacent cycles, and each strobe follows an accepted sample. The stimulus keeps within this by driving whole samples through a task and by resetting only from idle. The same task inserts random idle gaps and drives random data on `in_sample` during those gaps. The exact sums are checked on constant, tone, extreme-value and random data, and again after a reset in the middle of a window.

// File: rtl/single_bin_dft.sv
module single_bin_dft #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 16,
  parameter int WIN_LEN  = 332,
  parameter int FREQ_NUM = 1,
  parameter int FREQ_DEN = 5,
  localparam int HOP     = WIN_LEN / 2,
  localparam int CNT_W   = $clog2(WIN_LEN),
  localparam int ACC_W   = SAMPLE_W + COEF_W + CNT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  output logic signed [ACC_W-1:0]    out_i,
  output logic signed [ACC_W-1:0]    out_q
);

  function automatic logic signed [COEF_W-1:0] make_coef(input int n, input bit quad);
    real pi, w, th, v;
    pi = 3.14159265358979323846;
    w  = 0.42 - 0.5 * $cos(2.0 * pi * real'(n) / real'(WIN_LEN - 1))
              + 0.08 * $cos(4.0 * pi * real'(n) / real'(WIN_LEN - 1));
    th = 2.0 * pi * real'(FREQ_NUM) * (real'(n) - real'(WIN_LEN) / 2.0) / real'(FREQ_DEN);
    v  = real'((1 << (COEF_W - 1)) - 1) * w * (quad ? -$sin(th) : $cos(th));
    return COEF_W'(v >= 0.0 ? $rtoi(v + 0.5) : $rtoi(v - 0.5));
  endfunction

  logic signed [COEF_W-1:0] rom_c [WIN_LEN];
  logic signed [COEF_W-1:0] rom_s [WIN_LEN];

  for (genvar g = 0; g < WIN_LEN; g++) begin : g_rom
    localparam logic signed [COEF_W-1:0] CV = make_coef(g, 1'b0);
    localparam logic signed [COEF_W-1:0] SV = make_coef(g, 1'b1);
    assign rom_c[g] = CV;
    assign rom_s[g] = SV;
  end

  logic [CNT_W-1:0]        cnt   [2];
  logic                    act   [2];
  logic signed [ACC_W-1:0] acc_i [2];
  logic signed [ACC_W-1:0] acc_q [2];
  logic signed [ACC_W-1:0] sum_i [2];
  logic signed [ACC_W-1:0] sum_q [2];
  logic                    last  [2];
  logic signed [ACC_W-1:0] x_ext;

  assign x_ext = ACC_W'(in_sample);

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      sum_i[l] = acc_i[l] + x_ext * ACC_W'(rom_c[cnt[l]]);
      sum_q[l] = acc_q[l] + x_ext * ACC_W'(rom_s[cnt[l]]);
      last[l]  = act[l] && (cnt[l] == CNT_W'(WIN_LEN - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        cnt[l]   <= '0;
        acc_i[l] <= '0;
        acc_q[l] <= '0;
      end
      act[0]    <= 1'b1;
      act[1]    <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (!act[1] && cnt[0] == CNT_W'(HOP - 1))
          act[1] <= 1'b1;
        for (int l = 0; l < 2; l++) begin
          if (act[l]) begin
            if (last[l]) begin
              cnt[l]    <= '0;
              acc_i[l]  <= '0;
              acc_q[l]  <= '0;
              out_valid <= 1'b1;
              out_i     <= sum_i[l];
              out_q     <= sum_q[l];
            end else begin
              cnt[l]   <= cnt[l] + 1'b1;
              acc_i[l] <= sum_i[l];
              acc_q[l] <= sum_q[l];
            end
          end
        end
      end
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_strobe_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_idle_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cnt[0]) && $stable(acc_i[0]) && $stable(acc_q[0])));

  assert_lane_stagger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act[1] |-> ((32'(cnt[1]) + HOP) % WIN_LEN) == 32'(cnt[0]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

// File: tb/test_single_bin_dft.sv
module test_single_bin_dft;
  localparam int N   = 332;
  localparam int HOP = 166;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic out_valid;
  logic signed [36:0] out_i, out_q;

  int total = 0, bad = 0, hold_bad = 0, cycles = 0;
  bit done = 0;
  longint cI [N];
  longint cQ [N];
  int hist[$];
  longint exp_i[$], exp_q[$];
  longint last_i = 0, last_q = 0;
  bit prev_valid = 0;

  always #2.5 clk = ~clk;

  single_bin_dft i_single_bin_dft (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  function automatic longint rnd(real v);
    return v >= 0.0 ? longint'($rtoi(v + 0.5)) : longint'($rtoi(v - 0.5));
  endfunction

  task automatic build_coefs();
    real pi = 3.14159265358979323846;
    for (int n = 0; n < N; n++) begin
      real w, th;
      w  = 0.42 - 0.5 * $cos(2.0 * pi * real'(n) / real'(N - 1))
                + 0.08 * $cos(4.0 * pi * real'(n) / real'(N - 1));
      th = 2.0 * pi * 1.0 * (real'(n) - real'(N) / 2.0) / 5.0;
      cI[n] = rnd(32767.0 * w * $cos(th));
      cQ[n] = rnd(32767.0 * w * -$sin(th));
    end
  endtask

  task automatic check(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: one accepted sample, then idle gap cycles with junk data
  task automatic send(int v, int gap);
    int s;
    hist.push_back(v);
    s = hist.size();
    if (s >= N && (s - N) % HOP == 0) begin
      longint si = 0, sq = 0;
      for (int k = 0; k < N; k++) begin
        si += longint'(hist[s - N + k]) * cI[k];
        sq += longint'(hist[s - N + k]) * cQ[k];
      end
      exp_i.push_back(si);
      exp_q.push_back(sq);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 12'(v);
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_sample = 12'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    hist.delete();
    exp_i.delete();
    exp_q.delete();
    last_i = 0;
    last_q = 0;
  endtask

  task automatic end_phase(string tag);
    repeat (4) @(negedge clk);
    check(exp_i.size() == 0, tag, exp_i.size(), 0);
    check(hold_bad == 0, "R8 hold", hold_bad, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        check(!prev_valid, "R5 strobe width", 2, 1);
        if (exp_i.size() == 0) begin
          check(1'b0, "R1/R4 unexpected result", 1, 0);
        end else begin
          longint ei, eq;
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          check(longint'(out_i) == ei, "R3 I sum", out_i, ei);
          check(longint'(out_q) == eq, "R3 Q sum", out_q, eq);
        end
        last_i = out_i;
        last_q = out_q;
      end else if (longint'(out_i) != last_i || longint'(out_q) != last_q) begin
        hold_bad++;
      end
      prev_valid = out_valid;
    end else begin
      prev_valid = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    build_coefs();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(out_i == 0, "R1 reset I", out_i, 0);
    check(out_q == 0, "R1 reset Q", out_q, 0);
    do_reset();

    // R1/R4: zeros, exact first-window timing
    for (int n = 0; n < 400; n++) send(0, 0);
    end_phase("R4 zeros count");

    // R2/R3: tone at the bin, peak at window centre
    do_reset();
    for (int n = 0; n < 700; n++)
      send(int'(rnd(2000.0 * $cos(2.0 * 3.14159265358979 * 0.2 * real'(n - 166)))), n % 3);
    end_phase("R2 tone count");

    // R3: extreme negative constant with gaps (R6)
    do_reset();
    for (int n = 0; n < 500; n++) send(-2048, (n % 5 == 0) ? 2 : 0);
    end_phase("R3 overflow count");

    // R3: alternating extremes
    do_reset();
    for (int n = 0; n < 500; n++) send((n % 2) ? 2047 : -2048, 0);
    end_phase("R3 alternate count");

    // R4/R6: random data with random idle gaps
    do_reset();
    for (int n = 0; n < 1200; n++)
      send(int'($signed(12'($urandom))), int'($urandom % 3));
    end_phase("R6 random count");

    // R7: reset in the middle of a window discards partial sums
    for (int n = 0; n < 250; n++) send(1500, 0);
    do_reset();
    for (int n = 0; n < 331; n++) send(-1000, 0);
    repeat (3) @(negedge clk);
    check(exp_i.size() == 0 && !out_valid, "R7 no early result", exp_i.size(), 0);
    send(-1000, 0);
    for (int n = 0; n < 10; n++) send(700, 0);
    end_phase("R7 after reset count");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule